// File: doc/BRIEF.md
# SPI Serial EEPROM Device Model

This block is a synthesizable SPI slave that behaves like a small serial EEPROM. Its purpose is to stand in for a real memory part, either in simulation or on an emulation platform, so that the bus-level habits of firmware meet a device that enforces the same rules a real part would. The chip-select framing of each command is enforced. A page write that runs past the end of its page wraps back to the start of that page. The write enable latch clears itself after an internal write cycle. The SPI pins are sampled by the system clock through a synchronizer, so SCK must run several times slower than the system clock.

Every frame starts with an instruction byte. Address bytes, and any data bytes that follow, come after it. Page-write data is collected in a page buffer. When chip select rises cleanly on a byte boundary, the buffer is copied into the array during a timed internal write cycle. While that cycle runs, the status busy bit reads 1.

Top module: `spi_eeprom_model`

## Requirements
- R1: The first byte after cs_n falls is always decoded as an instruction. Every later byte in the same frame is address or data, so an opcode value sent as a data byte (for example 0x04) is stored as plain data.
- R2: Instruction codes are as follows. 0x06 sets the write enable latch. 0x04 clears it. 0x05 reads status. 0x03 reads memory. 0x02 writes a page. Any other code is ignored, together with the rest of its frame, until cs_n rises. Each instruction takes effect when its eighth bit is received.
- R3: A read takes two address bytes, high byte first. It then returns data MSB first, one byte after another, from consecutive addresses for as long as SCK keeps clocking. The address selects byte (address mod MEM_BYTES), and it wraps at the end of the array. After reset every byte reads 0xFF.
- R4: During a page write, the offset within the page (the low log2(PAGE_BYTES) address bits) advances after each data byte. A byte sent past the last offset wraps to offset 0 of the same page and overwrites it. Neighbouring pages are never touched.
- R5: A write instruction issued while the write enable latch is clear is ignored. Memory is unchanged and no write cycle starts.
- R6: Buffered write data is committed only if cs_n rises after a whole number of data bytes, with at least one data byte. If the frame ends mid-byte, the data is discarded, no write cycle starts and the latch keeps its value.
- R7: The status byte has bit 0 = write cycle in progress and bit 1 = write enable latch; all other bits are 0. Bit 0 reads 1 for WRITE_CYCLES system clocks after a commit. A status read keeps returning the current status for every byte clocked in the same frame.
- R8: The write enable latch is clear after reset, and it is cleared automatically when a write cycle completes.
- R9: While a write cycle is in progress, every instruction other than a status read is ignored. Reads return 0x00 and do not change memory, and write-enable changes have no effect.
- R10: Both SPI mode 0 (SCK idles low) and mode 3 (SCK idles high) work. Input is sampled on rising SCK edges, and output bits change on falling SCK edges.
- R11: miso is held low while cs_n is high, and whenever no read or status data is being returned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SCK must be at least 8x slower |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | SPI serial clock from the master |
| cs_n | input | 1 | Active-low chip select that frames each command |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master |

## Verification
The bench builds the model with a 512-byte array, 64-byte pages and a write cycle of 2500 system clocks. The small array means an address with bits above bit 8 set aliases onto a low location, so the modulo addressing and the end-of-array wrap can be checked with a handful of bytes. The write cycle is long enough that a whole ignored write frame, an ignored read and a write-disable attempt all fit inside one busy window, and the bench then confirms that none of them took effect. The page tests start a few bytes before a page end, so the in-page wrap and the untouched next page are both observed.

// File: rtl/ee_pkg.sv
package ee_pkg;
   localparam logic [7:0] OP_SET_WEL = 8'h06;
   localparam logic [7:0] OP_CLR_WEL = 8'h04;
   localparam logic [7:0] OP_STATUS  = 8'h05;
   localparam logic [7:0] OP_READ    = 8'h03;
   localparam logic [7:0] OP_PROGRAM = 8'h02;

   typedef enum logic [2:0] {
      PH_CMD,
      PH_ADDR_HI,
      PH_ADDR_LO,
      PH_WDATA,
      PH_RDATA,
      PH_STAT,
      PH_SKIP
   } phase_t;
endpackage

// File: rtl/ee_sync_edge.sv
module ee_sync_edge #(
   parameter int               WIDTH   = 3,
   parameter int               STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,
   output logic [WIDTH-1:0] q_prev
);
   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain  <= {STAGES{RST_VAL}};
         q_prev <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
         q_prev <= chain[STAGES-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/ee_store.sv
module ee_store #(
   parameter int MEM_BYTES    = 1024,
   parameter int PAGE_BYTES   = 64,
   parameter int WRITE_CYCLES = 2000,
   parameter bit RESET_FILL   = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [$clog2(MEM_BYTES)-1:0] rd_addr,
   output logic [7:0]                   rd_data,
   input  logic                         buf_clr,
   input  logic                         buf_we,
   input  logic [$clog2(PAGE_BYTES)-1:0] buf_off,
   input  logic [7:0]                   buf_data,
   input  logic                         start,
   input  logic [$clog2(MEM_BYTES)-1:0] page_base,
   output logic                         pending,
   output logic                         busy,
   output logic                         done
);
   localparam int MA_W = $clog2(MEM_BYTES);
   localparam int PO_W = $clog2(PAGE_BYTES);
   localparam int TW   = $clog2(WRITE_CYCLES + 1);

   logic [7:0]            mem      [MEM_BYTES];
   logic [7:0]            page_buf [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] vld;
   logic [TW-1:0]         timer;
   logic [MA_W-1:0]       base_q;
   logic [PO_W-1:0]       cur_off;
   logic [MA_W-1:0]       wr_idx;
   logic                  commit_we;

   // page buffer: data has no reset, valid flags do
   always_ff @(posedge clk) begin
      if (buf_we) page_buf[buf_off] <= buf_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       vld <= '0;
      else if (buf_clr) vld <= '0;
      else if (buf_we)  vld[buf_off] <= 1'b1;
   end

   assign pending = |vld;

   // timed internal write cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         done   <= 1'b0;
         timer  <= '0;
         base_q <= '0;
      end else begin
         done <= 1'b0;
         if (start && !busy) begin
            busy   <= 1'b1;
            timer  <= '0;
            base_q <= page_base;
         end else if (busy) begin
            if (timer == TW'(WRITE_CYCLES - 1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               timer <= timer + 1'b1;
            end
         end
      end
   end

   assign cur_off   = timer[PO_W-1:0];
   assign wr_idx    = base_q | MA_W'(cur_off);
   assign commit_we = busy && (timer < TW'(PAGE_BYTES)) && vld[cur_off];

   // array variant: erased on reset, or left unreset for a lighter build
   if (RESET_FILL) begin : g_fill
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
         end else if (commit_we) begin
            mem[wr_idx] <= page_buf[cur_off];
         end
      end
   end else begin : g_nofill
      always_ff @(posedge clk) begin
         if (commit_we) mem[wr_idx] <= page_buf[cur_off];
      end
   end

   assign rd_data = mem[rd_addr];

   AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (timer < TW'(WRITE_CYCLES)));                       // R7
   AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);                                            // R9
   AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);                                             // R7
endmodule

// File: rtl/ee_ctrl.sv
module ee_ctrl
   import ee_pkg::*;
#(
   parameter int MEM_BYTES  = 1024,
   parameter int PAGE_BYTES = 64
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          sck_s,
   input  logic                          sck_p,
   input  logic                          cs_s,
   input  logic                          cs_p,
   input  logic                          mosi_s,
   input  logic                          busy,
   input  logic                          done,
   input  logic                          pending,
   input  logic [7:0]                    rd_data,
   output logic [$clog2(MEM_BYTES)-1:0]  rd_addr,
   output logic                          buf_clr,
   output logic                          buf_we,
   output logic [$clog2(PAGE_BYTES)-1:0] buf_off,
   output logic [7:0]                    buf_data,
   output logic                          start,
   output logic [$clog2(MEM_BYTES)-1:0]  page_base,
   output logic                          miso
);
   localparam int MA_W = $clog2(MEM_BYTES);
   localparam int PO_W = $clog2(PAGE_BYTES);

   phase_t      phase;
   logic [2:0]  bit_cnt;
   logic [6:0]  rx_shift;
   logic [7:0]  rx_byte;
   logic [15:0] addr;
   logic        is_wr;
   logic        wel;
   logic [7:0]  tx;
   logic        sck_rise, sck_fall, cs_rise;

   assign sck_rise  = sck_s & ~sck_p;
   assign sck_fall  = ~sck_s & sck_p;
   assign cs_rise   = cs_s & ~cs_p;
   assign rx_byte   = {rx_shift, mosi_s};
   assign rd_addr   = addr[MA_W-1:0];
   assign page_base = {addr[MA_W-1:PO_W], {PO_W{1'b0}}};
   assign miso      = tx[7];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_CMD;
         bit_cnt  <= '0;
         rx_shift <= '0;
         addr     <= '0;
         is_wr    <= 1'b0;
         wel      <= 1'b0;
         tx       <= '0;
         buf_clr  <= 1'b0;
         buf_we   <= 1'b0;
         buf_off  <= '0;
         buf_data <= '0;
         start    <= 1'b0;
      end else begin
         buf_clr <= 1'b0;
         buf_we  <= 1'b0;
         start   <= 1'b0;
         if (cs_s) begin
            // frame boundary: commit only on a whole byte
            if (cs_rise && phase == PH_WDATA && bit_cnt == 3'd0 && pending)
               start <= 1'b1;
            phase   <= PH_CMD;
            bit_cnt <= '0;
            tx      <= '0;
         end else if (sck_rise) begin
            bit_cnt  <= bit_cnt + 1'b1;
            rx_shift <= rx_byte[6:0];
            if (bit_cnt == 3'd7) begin
               unique case (phase)
                  PH_CMD: begin
                     phase <= PH_SKIP;
                     if (rx_byte == OP_SET_WEL && !busy) wel <= 1'b1;
                     else if (rx_byte == OP_CLR_WEL && !busy) wel <= 1'b0;
                     else if (rx_byte == OP_STATUS) phase <= PH_STAT;
                     else if (rx_byte == OP_READ && !busy) begin
                        phase <= PH_ADDR_HI;
                        is_wr <= 1'b0;
                     end else if (rx_byte == OP_PROGRAM && !busy && wel) begin
                        phase   <= PH_ADDR_HI;
                        is_wr   <= 1'b1;
                        buf_clr <= 1'b1;
                     end
                  end
                  PH_ADDR_HI: begin
                     addr[15:8] <= rx_byte;
                     phase      <= PH_ADDR_LO;
                  end
                  PH_ADDR_LO: begin
                     addr[7:0] <= rx_byte;
                     phase     <= is_wr ? PH_WDATA : PH_RDATA;
                  end
                  PH_WDATA: begin
                     buf_we          <= 1'b1;
                     buf_off         <= addr[PO_W-1:0];
                     buf_data        <= rx_byte;
                     addr[PO_W-1:0]  <= addr[PO_W-1:0] + 1'b1;
                  end
                  default: ;
               endcase
            end
         end else if (sck_fall) begin
            if (bit_cnt == 3'd0) begin
               unique case (phase)
                  PH_RDATA: begin
                     tx   <= rd_data;
                     addr <= addr + 1'b1;
                  end
                  PH_STAT: tx <= {6'b0, wel, busy};
                  default: tx <= '0;
               endcase
            end else begin
               tx <= {tx[6:0], 1'b0};
            end
         end
         if (done) wel <= 1'b0;
      end
   end

   AST_WRITE_NEEDS_WEL: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> wel);                                              // R5
   AST_WEL_AUTOCLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !wel);                                              // R8
   AST_MISO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_s |=> !miso);                                             // R11
   AST_BUSY_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (phase == PH_CMD || phase == PH_STAT || phase == PH_SKIP)); // R9
endmodule

// File: rtl/spi_eeprom_model.sv
module spi_eeprom_model #(
   parameter int MEM_BYTES    = 1024,
   parameter int PAGE_BYTES   = 64,
   parameter int WRITE_CYCLES = 2000,
   parameter int SYNC_STAGES  = 2,
   parameter bit RESET_FILL   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sck,
   input  logic cs_n,
   input  logic mosi,
   output logic miso
);
   localparam int MA_W = $clog2(MEM_BYTES);
   localparam int PO_W = $clog2(PAGE_BYTES);

   if (PAGE_BYTES < 2 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if ((MEM_BYTES & (MEM_BYTES - 1)) != 0 || MA_W > 16 || MA_W <= PO_W) begin : g_bad_mem
      $error("MEM_BYTES must be a power of two above PAGE_BYTES and at most 65536");
   end
   if (WRITE_CYCLES < PAGE_BYTES) begin : g_bad_cyc
      $error("WRITE_CYCLES must cover one clock per page byte");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [2:0]      pins_s, pins_p;
   logic            busy, done, pending, buf_clr, buf_we, start;
   logic [MA_W-1:0] rd_addr, page_base;
   logic [7:0]      rd_data, buf_data;
   logic [PO_W-1:0] buf_off;

   ee_sync_edge #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cs_n, sck, mosi}), .q(pins_s), .q_prev(pins_p)
   );

   ee_ctrl #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .sck_s(pins_s[1]), .sck_p(pins_p[1]), .cs_s(pins_s[2]), .cs_p(pins_p[2]),
      .mosi_s(pins_s[0]), .busy(busy), .done(done), .pending(pending),
      .rd_data(rd_data), .rd_addr(rd_addr), .buf_clr(buf_clr), .buf_we(buf_we),
      .buf_off(buf_off), .buf_data(buf_data), .start(start),
      .page_base(page_base), .miso(miso)
   );

   ee_store #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES),
              .WRITE_CYCLES(WRITE_CYCLES), .RESET_FILL(RESET_FILL)) u_store (
      .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
      .buf_clr(buf_clr), .buf_we(buf_we), .buf_off(buf_off), .buf_data(buf_data),
      .start(start), .page_base(page_base), .pending(pending),
      .busy(busy), .done(done)
   );
endmodule

// File: tb/spi_eeprom_model_test.sv
module spi_eeprom_model_test;
   localparam int MEMB = 512;
   localparam int WCYC = 2500;
   localparam int HALF = 8;

   logic clk = 1'b0, rst_n = 1'b0, sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
   wire  miso;
   int   n_checks = 0, n_fail = 0;
   bit   mode3 = 1'b0;
   bit   finished = 1'b0;

   always #2 clk = ~clk;

   spi_eeprom_model #(.MEM_BYTES(MEMB), .PAGE_BYTES(64), .WRITE_CYCLES(WCYC)) uut (
      .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
   );

   task automatic clks(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic spi_bits(input logic [7:0] o, input int n, output logic [7:0] i);
      i = '0;
      for (int k = 0; k < n; k++) begin
         if (mode3) sck = 1'b0;
         mosi = o[7-k];
         clks(HALF);
         i = {i[6:0], miso};
         sck = 1'b1;
         clks(HALF);
         if (!mode3) sck = 1'b0;
      end
   endtask

   task automatic spi_byte(input logic [7:0] o, output logic [7:0] i);
      spi_bits(o, 8, i);
   endtask

   task automatic sel();
      sck = mode3;
      cs_n = 1'b0;
      clks(HALF);
   endtask

   task automatic desel();
      clks(HALF);
      cs_n = 1'b1;
      clks(2 * HALF);
   endtask

   task automatic cmd1(input logic [7:0] op);
      logic [7:0] d;
      sel(); spi_byte(op, d); desel();
   endtask

   task automatic rd_status(output logic [7:0] st);
      logic [7:0] d;
      sel(); spi_byte(8'h05, d); spi_byte(8'h00, st); desel();
   endtask

   task automatic wr_page(input logic [15:0] a, input logic [7:0] b [4], input int n);
      logic [7:0] d;
      sel();
      spi_byte(8'h02, d); spi_byte(a[15:8], d); spi_byte(a[7:0], d);
      for (int k = 0; k < n; k++) spi_byte(b[k], d);
      desel();
   endtask

   task automatic rd_mem(input logic [15:0] a, input int n, output logic [7:0] b [4]);
      logic [7:0] d;
      sel();
      spi_byte(8'h03, d); spi_byte(a[15:8], d); spi_byte(a[7:0], d);
      for (int k = 0; k < 4; k++) b[k] = 8'h00;
      for (int k = 0; k < n; k++) spi_byte(8'h00, b[k]);
      desel();
   endtask

   task automatic t_reset();
      logic [7:0] st;
      logic [7:0] b [4];
      check("R11 miso idle after reset", {7'b0, miso}, 8'h00);
      rd_status(st);
      check("R8 status after reset", st, 8'h00);
      rd_mem(16'h0000, 1, b);
      check("R3 erased byte after reset", b[0], 8'hFF);
   endtask

   task automatic t_latch();
      logic [7:0] st, d;
      cmd1(8'h06);
      rd_status(st);
      check("R2 set-latch code 0x06", st, 8'h02);
      cmd1(8'h04);
      rd_status(st);
      check("R2 clear-latch code 0x04", st, 8'h00);
      sel(); spi_byte(8'hAB, d); spi_byte(8'h06, d); desel();
      rd_status(st);
      check("R1 opcode after unknown byte ignored", st, 8'h00);
   endtask

   task automatic t_no_wel();
      logic [7:0] st;
      logic [7:0] b [4];
      b = '{8'h55, 8'h00, 8'h00, 8'h00};
      wr_page(16'h0010, b, 1);
      rd_status(st);
      check("R5 no busy without latch", st, 8'h00);
      rd_mem(16'h0010, 1, b);
      check("R5 memory unchanged", b[0], 8'hFF);
   endtask

   task automatic t_page();
      logic [7:0] st;
      logic [7:0] b [4];
      cmd1(8'h06);
      b = '{8'h11, 8'h22, 8'h33, 8'h04};
      wr_page(16'h0040, b, 4);
      rd_status(st);
      check("R7 busy and latch during cycle", st, 8'h03);
      clks(WCYC + 100);
      rd_status(st);
      check("R8 latch cleared after cycle", st, 8'h00);
      rd_mem(16'h0040, 4, b);
      check("R3 first byte", b[0], 8'h11);
      check("R3 consecutive byte", b[1], 8'h22);
      check("R3 third byte", b[2], 8'h33);
      check("R1 opcode value stored as data", b[3], 8'h04);
   endtask

   task automatic t_wrap();
      logic [7:0] b [4];
      cmd1(8'h06);
      b = '{8'hA0, 8'hA1, 8'hA2, 8'hA3};
      wr_page(16'h00BE, b, 4);
      clks(WCYC + 100);
      rd_mem(16'h0080, 2, b);
      check("R4 wrapped byte at offset 0", b[0], 8'hA2);
      check("R4 wrapped byte at offset 1", b[1], 8'hA3);
      rd_mem(16'h00BE, 3, b);
      check("R4 byte at page end-2", b[0], 8'hA0);
      check("R4 byte at page end-1", b[1], 8'hA1);
      check("R4 next page untouched", b[2], 8'hFF);
   endtask

   task automatic t_abort();
      logic [7:0] st, d;
      logic [7:0] b [4];
      cmd1(8'h06);
      sel();
      spi_byte(8'h02, d); spi_byte(8'h01, d); spi_byte(8'h00, d);
      spi_byte(8'h77, d); spi_bits(8'hE0, 3, d);
      desel();
      rd_status(st);
      check("R6 partial byte: no cycle, latch kept", st, 8'h02);
      rd_mem(16'h0100, 1, b);
      check("R6 partial byte discarded", b[0], 8'hFF);
      cmd1(8'h04);
   endtask

   task automatic t_busy();
      logic [7:0] st;
      logic [7:0] b [4];
      cmd1(8'h06);
      b = '{8'h5A, 8'h00, 8'h00, 8'h00};
      wr_page(16'h0180, b, 1);
      b = '{8'h99, 8'h00, 8'h00, 8'h00};
      wr_page(16'h01C0, b, 1);
      rd_mem(16'h0180, 2, b);
      check("R9 read during cycle returns zero", b[0], 8'h00);
      check("R11 miso low on ignored read", b[1], 8'h00);
      cmd1(8'h04);
      rd_status(st);
      check("R9 clear-latch ignored while busy", st, 8'h03);
      clks(WCYC + 100);
      rd_mem(16'h01C0, 1, b);
      check("R9 write during cycle ignored", b[0], 8'hFF);
      rd_mem(16'h0180, 1, b);
      check("R9 original write committed", b[0], 8'h5A);
   endtask

   task automatic t_mode3();
      logic [7:0] st;
      logic [7:0] b [4];
      mode3 = 1'b1;
      sck = 1'b1;
      clks(4 * HALF);
      cmd1(8'h06);
      rd_status(st);
      check("R10 mode 3 status", st, 8'h02);
      b = '{8'hC3, 8'h00, 8'h00, 8'h00};
      wr_page(16'h0205, b, 1);
      clks(WCYC + 100);
      rd_mem(16'h0005, 1, b);
      check("R10 mode 3 write/read via alias", b[0], 8'hC3);
      mode3 = 1'b0;
      sck = 1'b0;
      clks(4 * HALF);
      rd_mem(16'h01FF, 3, b);
      check("R3 last array byte", b[0], 8'hFF);
      check("R3 read wraps to byte 0", b[1], 8'hFF);
      rd_mem(16'hFE04, 2, b);
      check("R3 upper address bits ignored", b[1], 8'hC3);
   endtask

   initial begin
      clks(5);
      rst_n = 1'b1;
      clks(10);
      t_reset();
      t_latch();
      t_no_wel();
      t_page();
      t_wrap();
      t_abort();
      t_busy();
      t_mode3();
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (190000) @(posedge clk);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end
endmodule